// File: doc/BRIEF.md
# Aligned Power-of-Two Region Programmer

This block is a hardware sequencer that turns one protected region, given as a base address and a length, into entries of a range filter table. The filter only accepts ranges that are powers of two in size and aligned to their own size. The sequencer therefore splits the request greedily. At each step it takes the biggest aligned power-of-two piece that still fits, stores that piece in the lowest free table entry, and moves on. It stops when nothing is left, when a piece cannot be encoded, or when the table has no free entry.

A requester drives a one-cycle start together with the address, the length and a two-bit permission. The block then writes the table through a single-word write port and reads back the entries' valid bits to find free slots. It ends with a one-cycle `done` pulse, or with an `error` flag that stays raised until the next accepted start. Each granule candidate takes one cycle, and so does each slot probe.

Top module: `rgn_programmer`

## Requirements
- R1: The block accepts a start only while idle. Each piece it emits is the largest power of two, from 2^31 bytes down to 2^12 bytes, that does not exceed the remaining length and to which the current address is aligned. After each piece the address advances by the piece size and the remaining length shrinks by the same amount.
- R2: If no power of two of at least 4 KB satisfies R1 while length remains, the block raises `error` and stops writing.
- R3: A piece smaller than 1 MB is rejected: `error` rises and that piece is not written. Every written piece starts on a 1 MB boundary and is aligned to its own size.
- R4: The size code in bits [11:7] of the written word equals log2(piece bytes) − 12, so 1 MB gives 8 and 2 GB gives 19.
- R5: Each piece goes to the lowest-numbered of the 16 entries whose valid bit reads clear.
- R6: If all 16 valid bits are set when a piece needs a slot, `error` rises and no write happens for that piece.
- R7: The written word has the following layout. Bit 0 = 1 (valid). Bits [2:1] = the command permission. Bit 3 = 0. Bits [5:4] = 00 (read-write for the region outside all entries). Bit 6 = 0 (its zero flag cleared). Bits [31:12] = piece address bits [31:12].
- R8: `done` is high for exactly one cycle when the remaining length reaches zero. `error` stays high until the next accepted start clears it, and it is never high together with `done`.
- R9: A start that arrives while `busy` is high is ignored and does not change the writes in progress.
- R10: A zero length finishes with a `done` pulse and no table write.
- R11: After reset, `busy`, `done`, `error` and `tbl_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle request to program a region |
| cmd_addr | input | 32 | Region base byte address |
| cmd_size | input | 32 | Region length in bytes |
| cmd_perm | input | 2 | Permission code stored in each entry |
| tbl_valid | input | 16 | Valid bit of each table entry, read back |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_idx | output | 4 | Entry index being written |
| tbl_wr_data | output | 32 | Range word being written |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Sticky failure flag |

## Verification
The slot-target check assumes that `tbl_valid` mirrors the table. A bit must not already be set for an entry in the cycle that entry is written, and the bit must become set after the write. The bench meets this with a table model that sets the bit on the clock edge that ends the write cycle. Between commands it loads valid patterns only while the block is idle. The sticky-error check assumes that starts during a busy phase are dropped. The bench issues its overlapping start only while `busy` is high.

// File: rtl/rgn_prog_pkg.sv
package rgn_prog_pkg;
    localparam int ADDR_W   = 32;  // byte address and length width
    localparam int LG_W     = 5;   // width of a log2 granule value
    localparam int MAX_LG   = 31;  // largest granule tried (2 GB)
    localparam int MIN_LG   = 12;  // smallest granule tried (4 KB)
    localparam int UNIT_LG  = 20;  // encodable minimum (1 MB)

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIND_GRAN,
        ST_CHECK,
        ST_FIND_SLOT,
        ST_WRITE,
        ST_DONE,
        ST_ERROR
    } prog_state_t;

    // Range word, MSB first; bit positions are decoded by the filter.
    typedef struct packed {
        logic [ADDR_W-MIN_LG-1:0] base;     // [31:12]
        logic [4:0]               code;     // [11:7]
        logic                     ur_zero;  // [6]
        logic [1:0]               ur_perm;  // [5:4]
        logic                     zero;     // [3]
        logic [1:0]               perm;     // [2:1]
        logic                     valid;    // [0]
    } range_word_t;

    localparam logic [1:0] PERM_RW = 2'b00;

    function automatic logic [ADDR_W-1:0] lg_to_bytes(input logic [LG_W-1:0] lg);
        return ADDR_W'(1) << lg;
    endfunction
endpackage

// File: rtl/rgn_gran_scan.sv
module rgn_gran_scan
    import rgn_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] remain,
    output logic [LG_W-1:0]   lg,
    output logic [ADDR_W-1:0] gran,
    output logic              hit,
    output logic              at_min
);
    always_ff @(posedge clk) begin
        if (rst)       lg <= LG_W'(MAX_LG);
        else if (load) lg <= LG_W'(MAX_LG);
        else if (step) lg <= lg - LG_W'(1);
    end

    always_comb begin
        gran   = lg_to_bytes(lg);
        hit    = (gran <= remain) && ((addr & (gran - ADDR_W'(1))) == '0);
        at_min = (lg == LG_W'(MIN_LG));
    end
endmodule

// File: rtl/rgn_slot_scan.sv
module rgn_slot_scan #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [N_ENT-1:0] valid,
    output logic [IDX_W-1:0] ptr,
    output logic             free,
    output logic             at_last
);
    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= '0;
        else if (step) ptr <= ptr + IDX_W'(1);
    end

    always_comb begin
        free    = !valid[ptr];
        at_last = (ptr == IDX_W'(N_ENT - 1));
    end
endmodule

// File: rtl/rgn_word_pack.sv
module rgn_word_pack
    import rgn_prog_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [4:0]        code,
    input  logic [1:0]        perm,
    output logic [ADDR_W-1:0] word
);
    range_word_t w;
    always_comb begin
        w.base    = addr[ADDR_W-1:MIN_LG];
        w.code    = code;
        w.ur_zero = 1'b0;
        w.ur_perm = PERM_RW;
        w.zero    = 1'b0;
        w.perm    = perm;
        w.valid   = 1'b1;
        word      = w;
    end
endmodule

// File: rtl/rgn_programmer.sv
module rgn_programmer
    import rgn_prog_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] cmd_size,
    input  logic [1:0]        cmd_perm,
    input  logic [N_ENT-1:0]  tbl_valid,
    output logic              tbl_wr_en,
    output logic [IDX_W-1:0]  tbl_wr_idx,
    output logic [ADDR_W-1:0] tbl_wr_data,
    output logic              busy,
    output logic              done,
    output logic              error
);
    prog_state_t       state;
    logic [ADDR_W-1:0] addr_q, rem_q;
    logic [1:0]        perm_q;
    logic [4:0]        code_q;
    logic              err_q;

    logic              accept;
    logic              g_load, g_step, g_hit, g_min;
    logic [LG_W-1:0]   g_lg;
    logic [ADDR_W-1:0] g_gran;
    logic              s_load, s_step, s_free, s_last;
    logic [IDX_W-1:0]  s_ptr;
    logic              piece_ok;

    assign accept   = (state == ST_IDLE) && cmd_start;
    assign piece_ok = (g_lg >= LG_W'(UNIT_LG)) && (addr_q[UNIT_LG-1:0] == '0);

    assign g_load = accept || (state == ST_WRITE);
    assign g_step = (state == ST_FIND_GRAN) && (rem_q != '0) && !g_hit && !g_min;
    assign s_load = (state == ST_CHECK);
    assign s_step = (state == ST_FIND_SLOT) && !s_free && !s_last;

    rgn_gran_scan u_gran (
        .clk(clk), .rst(rst), .load(g_load), .step(g_step),
        .addr(addr_q), .remain(rem_q),
        .lg(g_lg), .gran(g_gran), .hit(g_hit), .at_min(g_min)
    );

    rgn_slot_scan #(.N_ENT(N_ENT)) u_slot (
        .clk(clk), .rst(rst), .load(s_load), .step(s_step),
        .valid(tbl_valid), .ptr(s_ptr), .free(s_free), .at_last(s_last)
    );

    rgn_word_pack u_pack (
        .addr(addr_q), .code(code_q), .perm(perm_q), .word(tbl_wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            rem_q  <= '0;
            perm_q <= '0;
            code_q <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_start) begin
                    addr_q <= cmd_addr;
                    rem_q  <= cmd_size;
                    perm_q <= cmd_perm;
                    err_q  <= 1'b0;
                    state  <= ST_FIND_GRAN;
                end
                ST_FIND_GRAN: begin
                    if (rem_q == '0)  state <= ST_DONE;
                    else if (g_hit)   state <= ST_CHECK;
                    else if (g_min) begin
                        state <= ST_ERROR;
                        err_q <= 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (piece_ok) begin
                        code_q <= 5'(g_lg - LG_W'(MIN_LG));
                        state  <= ST_FIND_SLOT;
                    end else begin
                        state <= ST_ERROR;
                        err_q <= 1'b1;
                    end
                end
                ST_FIND_SLOT: begin
                    if (s_free) state <= ST_WRITE;
                    else if (s_last) begin
                        state <= ST_ERROR;
                        err_q <= 1'b1;
                    end
                end
                ST_WRITE: begin
                    addr_q <= addr_q + g_gran;
                    rem_q  <= rem_q - g_gran;
                    state  <= ST_FIND_GRAN;
                end
                ST_DONE:  state <= ST_IDLE;
                ST_ERROR: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign tbl_wr_en  = (state == ST_WRITE);
    assign tbl_wr_idx = s_ptr;
    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_DONE);
    assign error      = err_q;
endmodule

// File: rtl/rgn_programmer_chk.sv
module rgn_programmer_chk #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_start,
    input logic [N_ENT-1:0] tbl_valid,
    input logic             tbl_wr_en,
    input logic [IDX_W-1:0] tbl_wr_idx,
    input logic [31:0]      tbl_wr_data,
    input logic             busy,
    input logic             done,
    input logic             error
);
    // R5: the target entry reads free in its write cycle
    a_r5_target_free: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> !tbl_valid[tbl_wr_idx]);

    // R6: a full table never receives a write
    a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> (tbl_valid != {N_ENT{1'b1}}));

    // R7: fixed fields of every written word
    a_r7_word_fields: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> (tbl_wr_data[0] && tbl_wr_data[6:3] == 4'b0000));

    // R3: code of at least 1 MB and base aligned to the piece size
    a_r3_piece_encodable: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> (tbl_wr_data[11:7] >= 5'd8 &&
            ((32'(tbl_wr_data[31:12]) & ((32'd1 << tbl_wr_data[11:7]) - 32'd1)) == 32'd0)));

    // R8: done lasts one cycle and never coincides with error
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_done_not_error: assert property (@(posedge clk) disable iff (rst)
        !(done && error));
    // R8 and R9: error holds unless a start is accepted
    a_r8_error_sticky: assert property (@(posedge clk) disable iff (rst)
        (error && !(cmd_start && !busy)) |=> error);

    // R10 and R11: writes and done only while busy
    a_r11_outputs_need_busy: assert property (@(posedge clk) disable iff (rst)
        (tbl_wr_en || done) |-> busy);
endmodule

bind rgn_programmer rgn_programmer_chk #(.N_ENT(N_ENT)) i_chk (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .tbl_valid(tbl_valid),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
    .busy(busy), .done(done), .error(error)
);

// File: tb/test_rgn_programmer.sv
module test_rgn_programmer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_size = '0;
    logic [1:0]  cmd_perm = '0;
    logic [15:0] tv = '0;
    logic        tbl_wr_en;
    logic [3:0]  tbl_wr_idx;
    logic [31:0] tbl_wr_data;
    logic        busy, done, error;

    int checks = 0;
    int errors = 0;
    int n_w = 0;
    int done_cnt = 0;
    int cycles = 0;
    bit reported = 0;
    logic [3:0]  w_idx [0:15];
    logic [31:0] w_dat [0:15];

    always #4 clk = ~clk;  // 125 MHz

    rgn_programmer i_rgn_programmer (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .cmd_size(cmd_size), .cmd_perm(cmd_perm), .tbl_valid(tv),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
        .busy(busy), .done(done), .error(error)
    );

    // Table model: a written entry becomes valid at the edge ending the write.
    always @(posedge clk) begin
        if (!rst && tbl_wr_en) begin
            tv[tbl_wr_idx] <= 1'b1;
            if (n_w < 16) begin
                w_idx[n_w] <= tbl_wr_idx;
                w_dat[n_w] <= tbl_wr_data;
            end
            n_w <= n_w + 1;
        end
    end

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog: run did not finish, got %0d cycles, expected below 100000", cycles);
                summary();
                $finish;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic [31:0] a, input logic [4:0] code,
                                         input logic [1:0] perm);
        return {a[31:12], code, 4'b0000, perm, 1'b1};
    endfunction

    // Issue a command; optionally pulse a second start after 'poke' busy cycles.
    task automatic run(input logic [31:0] a, input logic [31:0] s, input logic [1:0] p,
                       input int poke);
        @(negedge clk);
        n_w = 0; done_cnt = 0;
        cmd_addr = a; cmd_size = s; cmd_perm = p; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int k = 1; busy && k < 2000; k++) begin
            if (done) done_cnt++;
            if (k == poke) begin
                cmd_addr = 32'h7000_0000; cmd_size = 32'h0010_0000;
                cmd_perm = 2'b11; cmd_start = 1'b1;
            end else begin
                cmd_start = 1'b0;
            end
            @(negedge clk);
        end
        cmd_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 busy", 32'(busy), 0);
        chk("R11 done", 32'(done), 0);
        chk("R11 error", 32'(error), 0);
        chk("R11 wr_en", 32'(tbl_wr_en), 0);
    endtask

    task automatic t_single();
        tv = '0;
        run(32'h0010_0000, 32'h0010_0000, 2'b11, 0);
        chk("R8 done count", done_cnt, 1);
        chk("R1 write count", n_w, 1);
        chk("R5 idx", 32'(w_idx[0]), 0);
        chk("R7 word entry0", w_dat[0], word(32'h0010_0000, 5'd8, 2'b11));
    endtask

    task automatic t_split();
        run(32'h0010_0000, 32'h0030_0000, 2'b01, 0);
        chk("R1 write count split", n_w, 2);
        chk("R5 idx first", 32'(w_idx[0]), 1);
        chk("R4 word 1MB", w_dat[0], word(32'h0010_0000, 5'd8, 2'b01));
        chk("R5 idx second", 32'(w_idx[1]), 2);
        chk("R4 word 2MB", w_dat[1], word(32'h0020_0000, 5'd9, 2'b01));
        chk("R8 error clear", 32'(error), 0);
    endtask

    task automatic t_skip();
        tv = 16'h002F;
        run(32'h4000_0000, 32'h4000_0000, 2'b10, 0);
        chk("R5 skip count", n_w, 1);
        chk("R5 lowest free", 32'(w_idx[0]), 4);
        chk("R4 word 1GB", w_dat[0], word(32'h4000_0000, 5'd18, 2'b10));
    endtask

    task automatic t_max();
        tv = '0;
        run(32'h0000_0000, 32'h8000_0000, 2'b00, 0);
        chk("R1 max count", n_w, 1);
        chk("R4 word 2GB", w_dat[0], word(32'h0, 5'd19, 2'b00));
    endtask

    task automatic t_full();
        tv = 16'hFFFF;
        run(32'h0010_0000, 32'h0010_0000, 2'b00, 0);
        chk("R6 error", 32'(error), 1);
        chk("R6 no write", n_w, 0);
        chk("R8 no done", done_cnt, 0);
        repeat (5) @(negedge clk);
        chk("R8 error held", 32'(error), 1);
    endtask

    task automatic t_partial_full();
        tv = 16'h7FFF;
        run(32'h0010_0000, 32'h0020_0000, 2'b01, 0);
        chk("R6 partial count", n_w, 1);
        chk("R6 partial idx", 32'(w_idx[0]), 15);
        chk("R6 partial error", 32'(error), 1);
    endtask

    task automatic t_small_piece();
        tv = '0;
        run(32'h0000_1000, 32'h0000_1000, 2'b00, 0);
        chk("R3 error", 32'(error), 1);
        chk("R3 no write", n_w, 0);
        tv = '0;
        run(32'h0010_0000, 32'h0010_1000, 2'b11, 0);
        chk("R3 tail count", n_w, 1);
        chk("R3 tail word", w_dat[0], word(32'h0010_0000, 5'd8, 2'b11));
        chk("R3 tail error", 32'(error), 1);
    endtask

    task automatic t_no_granule();
        tv = '0;
        run(32'h0000_0000, 32'h0000_0800, 2'b00, 0);
        chk("R2 error", 32'(error), 1);
        chk("R2 no write", n_w, 0);
    endtask

    task automatic t_zero();
        tv = '0;
        run(32'h0010_0000, 32'h0, 2'b00, 0);
        chk("R10 done", done_cnt, 1);
        chk("R10 no write", n_w, 0);
        chk("R8 error cleared by start", 32'(error), 0);
        chk("R10 table untouched", 32'(tv), 0);
    endtask

    task automatic t_busy_start();
        tv = '0;
        run(32'h0010_0000, 32'h0030_0000, 2'b10, 3);
        chk("R9 count", n_w, 2);
        chk("R9 word a", w_dat[0], word(32'h0010_0000, 5'd8, 2'b10));
        chk("R9 word b", w_dat[1], word(32'h0020_0000, 5'd9, 2'b10));
        chk("R9 idle after", 32'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_split();
        t_skip();
        t_max();
        t_full();
        t_partial_full();
        t_small_piece();
        t_no_granule();
        t_zero();
        t_busy_start();
        summary();
        $finish;
    end
endmodule